// File: doc/BRIEF.md
# Bit-Toggle Interval Timer

This block is a free-running binary counter that advances by one on each clock edge where a low-frequency tick enable is high. Software picks one bit of the count through a 5-bit selector. Each time a tick makes that bit change value, either from 0 to 1 or from 1 to 0, the block records an event. Selecting bit k therefore gives an event every 2^k ticks, which produces periodic interrupts at power-of-two intervals without any compare register.

An event raises a sticky status flag only while the action enable is high. The interrupt output is the status flag gated by that same enable. Software clears the flag with a single-cycle clear strobe, in write-one-to-clear style. The current count is also available as an output so it can be read.

Top module: `bit_toggle_timer`

## Requirements
- R1: During reset and in the cycle after it is released, `count_o` is 0, `stat_o` is 0 and `irq_o` is 0.
- R2: On each clock edge with `tick_en` high, `count_o` increases by one, modulo 2^CNT_W. With `tick_en` low, it holds its value.
- R3: A tick taken while the count is all ones wraps it to zero. That tick is an event for every in-range selection, including the top bit, which falls from 1 to 0.
- R4: `bit_sel` is a binary bit index, where 0 is the least significant bit. A tick is an event when it changes count bit `bit_sel` in either direction. For a selection k, this happens when bits k-1..0 of the count are all ones before the tick, so selection 0 is an event on every tick.
- R5: An event sets `stat_o` at the same edge that advances the count, but only while `irq_en` is high. With `irq_en` low, events leave `stat_o` unchanged.
- R6: `stat_o` stays set until a clock edge where `clr_stb` is high and no event is recorded. That edge clears it.
- R7: When an event is recorded at the same edge as a clear strobe, the event wins and `stat_o` is 1.
- R8: Whether a tick is an event depends only on the selected bit before and after that same tick. Changing `bit_sel` while no tick is taken never sets `stat_o`.
- R9: A `bit_sel` value of CNT_W or more selects no bit and never produces an event.
- R10: `irq_o` is high exactly when `stat_o` is high and `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Advance the count at this edge |
| bit_sel | input | SEL_W | Index of the watched count bit |
| irq_en | input | 1 | Action enable: events set the status flag |
| clr_stb | input | 1 | Clear strobe for the status flag |
| count_o | output | CNT_W | Current count |
| stat_o | output | 1 | Sticky event status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the timer with CNT_W = 10, which gives SEL_W = 4. With this width a full wrap takes only 1024 ticks, so the wrap event on the top bit is reachable. The selector can also take the values 10 to 15, which exercises selections past the counter width. Default-width elaboration (CNT_W = 32, SEL_W = 5) keeps the full selector range, but the top bits of that width cannot be reached in a short run.

// File: rtl/btt_pkg.sv
// Package: shared helpers for the bit-toggle interval timer.
// Assumes: widths are small positive integers.
package btt_pkg;
    // Width of an index that can address n bits (at least 1).
    function automatic int idx_width(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction
endpackage

// File: rtl/btt_counter.sv
// Module: btt_counter
// What it does: a free-running up counter that advances on a tick enable
// and wraps from all ones to zero.
// Assumes: rst_n is synchronous and active low.
module btt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Advance the count once per tick; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (tick_en) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));
    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (&cnt_q)) |=> cnt_q == '0);
endmodule

// File: rtl/btt_toggle_det.sv
// Module: btt_toggle_det
// What it does: decides whether the coming tick changes the selected bit.
// Bit k changes on an increment when all bits below k are ones, so a
// prefix-AND chain gives the toggle condition for every position.
// Assumes: the selection may exceed the counter width; such values
// select a zero entry and never signal an event.
module btt_toggle_det #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 5
) (
    input  logic             tick_en,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             evt_o
);
    localparam int SPAN = 1 << SEL_W;

    logic [SPAN-1:0] flips_w;

    // Build the carry-style chain: flips_w[k] = all bits below k are ones.
    for (genvar k = 0; k < SPAN; k++) begin : g_chain
        if (k == 0) begin : g_lsb
            assign flips_w[k] = 1'b1;
        end else if (k < CNT_W) begin : g_mid
            assign flips_w[k] = flips_w[k-1] & cnt_i[k-1];
        end else begin : g_pad
            assign flips_w[k] = 1'b0;
        end
    end

    // An event needs a tick and a selected bit that flips on it.
    always_comb begin
        evt_o = tick_en & flips_w[bit_sel];
    end

    // R9
    sel_range_chk: assert final (!(evt_o && (int'(bit_sel) >= CNT_W)));
endmodule

// File: rtl/btt_status.sv
// Module: btt_status
// What it does: a sticky event flag with a clear strobe; a set in the
// same cycle as a clear wins.
// Assumes: rst_n is synchronous and active low.
module btt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic stat_o
);
    logic stat_q;

    // Record events; clear only on a strobe with no event at that edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     stat_q <= 1'b0;
        else if (set_i) stat_q <= 1'b1;
        else if (clr_i) stat_q <= 1'b0;
    end

    assign stat_o = stat_q;

    // R5
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> stat_q);
    // R6
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !clr_i) |=> stat_q);
    // R6
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !stat_q);
endmodule

// File: rtl/bit_toggle_timer.sv
// Module: bit_toggle_timer
// What it does: a free-running counter that flags an event whenever a
// software-selected count bit changes value, giving power-of-two interrupt
// intervals. The status flag is sticky and cleared by a strobe.
// Assumes: tick_en is a single-cycle enable in the clk domain; rst_n is
// synchronous and active low.
module bit_toggle_timer #(
    parameter int CNT_W = 32,
    parameter int SEL_W = btt_pkg::idx_width(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             irq_en,
    input  logic             clr_stb,
    output logic [CNT_W-1:0] count_o,
    output logic             stat_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_w;
    logic             evt_w;
    logic             set_w;

    btt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_o   (cnt_w)
    );

    btt_toggle_det #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_det (
        .tick_en (tick_en),
        .bit_sel (bit_sel),
        .cnt_i   (cnt_w),
        .evt_o   (evt_w)
    );

    // Only enabled events reach the status flag.
    always_comb begin
        set_w = evt_w & irq_en;
    end

    btt_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_w),
        .clr_i  (clr_stb),
        .stat_o (stat_o)
    );

    assign count_o = cnt_w;

    // Gate the request with the action enable.
    always_comb begin
        irq_o = stat_o & irq_en;
    end

    // R4
    evt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_w |=> |((count_o ^ $past(count_o)) >> $past(bit_sel)));
    // R8
    no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !stat_o) |=> !stat_o);
    // R5
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o) |-> ($past(irq_en) && $past(tick_en)));
endmodule

// File: tb/tb_bit_toggle_timer.sv
module tb_bit_toggle_timer;
    localparam int CW = 10;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [SW-1:0] bit_sel = '0;
    logic          irq_en = 1'b0;
    logic          clr_stb = 1'b0;
    logic [CW-1:0] count_o;
    logic          stat_o;
    logic          irq_o;

    int checks = 0;
    int failures = 0;
    logic [CW-1:0] exp_cnt = '0;
    logic exp_stat = 1'b0;

    always #10 clk = ~clk;

    bit_toggle_timer #(.CNT_W(CW), .SEL_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bit_sel(bit_sel),
        .irq_en(irq_en), .clr_stb(clr_stb), .count_o(count_o),
        .stat_o(stat_o), .irq_o(irq_o)
    );

    // Does a tick from value c change bit k? Bits below k must all be ones.
    function automatic logic flips(input logic [CW-1:0] c, input int k);
        logic [31:0] m;
        if (k >= CW) return 1'b0;
        m = (32'd1 << k) - 32'd1;
        return ((32'(c) & m) == m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock with the given inputs; model the result, then compare.
    task automatic step(input logic te, input int sel, input logic en,
                        input logic clr, input string req);
        logic ev;
        @(negedge clk);
        tick_en = te; bit_sel = SW'(sel); irq_en = en; clr_stb = clr;
        ev = te && flips(exp_cnt, sel);
        if (te) exp_cnt = exp_cnt + CW'(1);
        if (ev && en) exp_stat = 1'b1;
        else if (clr) exp_stat = 1'b0;
        @(posedge clk); #1;
        check({req, " count"}, 32'(count_o), 32'(exp_cnt));
        check({req, " stat"}, 32'(stat_o), 32'(exp_stat));
        check("R10 irq", 32'(irq_o), 32'(exp_stat && en));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1;
        check("R1 count", 32'(count_o), 0);
        check("R1 stat", 32'(stat_o), 0);
        check("R1 irq", 32'(irq_o), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", 32'(count_o), 0);

        step(1, 0, 1, 0, "R4 lsb every tick");
        step(0, 0, 1, 1, "R6 clear");
        step(1, 1, 0, 0, "R5 disabled");
        step(1, 1, 0, 0, "R5 disabled");
        step(0, 0, 1, 0, "R2 hold");
        step(1, 2, 1, 0, "R4 bit2 rising at count 3");
        step(0, 2, 1, 0, "R6 sticky");
        step(1, 0, 1, 1, "R7 set beats clear");
        step(0, 0, 1, 1, "R6 clear");
        for (int s = 0; s < 16; s++) step(0, s, 1, 0, "R8 sel change no tick");
        for (int i = 0; i < 40; i++) step(1, 12 + (i % 4), 1, 0, "R9 out of range");
        step(0, 0, 1, 1, "R6 clear");
        while (exp_cnt != '1) step(1, CW - 1, 0, 0, "R2 run to top");
        step(1, CW - 1, 1, 0, "R3 wrap top bit falls");
        check("R3 wrap count zero", 32'(count_o), 0);

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom);
            step((r & 3) != 0, (r >> 2) & 15, ((r >> 6) & 3) != 0,
                 ((r >> 8) & 7) == 0, "R4 random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule